// File: doc/BRIEF.md
# Flash Embedded-Operation Status Byte Generator

This block forms the byte that a parallel flash device places on its data pins while a byte program, a sector erase or a whole-array erase is running inside it. A host that started such an operation polls the device with ordinary read cycles. Instead of array contents it then sees a small set of status flags. One flag mirrors the data being written or the erase state. Two flags flip on each read. Another reports that the operation overran its time budget, and another tells an erase from a program. When nothing is running, reads return the array byte unchanged. So a host can find out when the operation is done without a separate status register.

The operation engine is stood in for by a cycle counter with one parameterised length per operation kind, scaled far down from real microsecond and second durations. An operation can be flagged as stuck when it starts, so that the overrun path can be exercised. An erase can be held by a suspend input. During a suspend, reads of sectors that are not being erased return array data again.

Top module: `flash_op_status`

## Requirements
- R1: While no operation is active, `dq_out` equals `array_data` on every cycle.
- R2: During a byte program, bit 7 of `dq_out` is the inverse of bit 7 of the byte being programmed, and bits 5, 4, 3, 1 and 0 read 0. Exactly PROG_CYC cycles after the start edge, `dq_out` returns to `array_data`.
- R3: During an erase that is not suspended, bit 7 reads 0 and bit 3 reads 1. A sector erase (op_kind 1) lasts SERASE_CYC cycles and a whole-array erase (op_kind 2) lasts CERASE_CYC cycles.
- R4: While an operation is active and not suspended, bit 6 takes the opposite value on each successive qualified read, whichever sector is addressed.
- R5: A qualified read is a rising edge of `oe_n` while `ce_n` is low. A pulse of `oe_n` while `ce_n` is high does not advance either toggle bit.
- R6: Bit 2 flips on qualified reads of the erasing sector during a sector erase, and on reads of any sector during a whole-array erase. It holds on reads of other sectors and during a program.
- R7: While `erase_hold` is high during an erase, the duration counter stops. Reads of other sectors return `array_data`. Reads of the erasing sector show bit 7 = 1, bit 6 holding and bit 2 flipping. Once the hold is released, the erase finishes its remaining cycles.
- R8: An operation started with `op_stuck` set never completes. Bit 5 reads 0 up to LIMIT_CYC-1 cycles after the start edge and 1 from LIMIT_CYC cycles on, with status still shown, until `op_abort`. After `op_abort`, `array_data` shows on the next cycle.
- R9: A start request while an operation is active, or one with op_kind 3, is ignored.
- R10: Asserting `rst_n` low ends any operation, so `dq_out` follows `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 unused |
| op_data | input | 8 | Byte being programmed |
| op_sector | input | SECT_W | Sector addressed by the operation |
| op_stuck | input | 1 | Marks the operation as one that never completes |
| op_abort | input | 1 | Reset command, ends any operation |
| erase_hold | input | 1 | Suspends a running erase |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_sector | input | SECT_W | Sector of the current read address |
| array_data | input | 8 | Byte read from the array |
| dq_out | output | 8 | Byte returned to the host |

## Verification
If the busy state is stuck or is released too early, the status byte shows in the wrong cycle. A duration counted cycle by cycle against PROG_CYC, SERASE_CYC or CERASE_CYC exposes this on the first read after the faulty edge. A toggle flop that advances on the wrong strobe, or fails to advance, is seen after two reads: bit 6 or bit 2 repeats where it should flip, or flips where it should hold. A counter that keeps running during a hold shortens the rest of the erase, and an overrun flag set off by one edge is caught at the exact LIMIT_CYC boundary.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_SERASE = 2'd1,
      OP_CERASE = 2'd2,
      OP_RSVD   = 2'd3
   } op_kind_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/fsr_op_timer.sv
module fsr_op_timer
   import fsr_pkg::*;
#(
   parameter int unsigned PROG_CYC   = 16,
   parameter int unsigned SERASE_CYC = 64,
   parameter int unsigned CERASE_CYC = 128,
   parameter int unsigned LIMIT_CYC  = 200,
   parameter int unsigned SECT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_kind_e          kind_in,
   input  logic [BYTE_W-1:0] data_in,
   input  logic [SECT_W-1:0] sector_in,
   input  logic              stuck_in,
   input  logic              abort,
   input  logic              hold,
   output logic              busy,
   output logic              timeout,
   output logic              suspended,
   output op_kind_e          kind_q,
   output logic              data_msb,
   output logic [SECT_W-1:0] sector_q
);
   localparam int unsigned CNT_W = $clog2(LIMIT_CYC + 1);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last_cnt;
   logic [BYTE_W-1:0] data_q;
   logic              stuck_q;
   logic              paused;

   always_comb begin
      case (kind_q)
         OP_PROG:   last_cnt = CNT_W'(PROG_CYC - 1);
         OP_SERASE: last_cnt = CNT_W'(SERASE_CYC - 1);
         default:   last_cnt = CNT_W'(CERASE_CYC - 1);
      endcase
   end

   assign paused    = hold && (kind_q != OP_PROG);
   assign suspended = busy && paused;
   assign data_msb  = data_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         timeout  <= 1'b0;
         cnt      <= '0;
         kind_q   <= OP_PROG;
         data_q   <= '0;
         sector_q <= '0;
         stuck_q  <= 1'b0;
      end else if (abort) begin
         busy    <= 1'b0;
         timeout <= 1'b0;
         cnt     <= '0;
      end else if (!busy) begin
         if (start && (kind_in != OP_RSVD)) begin
            busy     <= 1'b1;
            cnt      <= '0;
            kind_q   <= kind_in;
            data_q   <= data_in;
            sector_q <= sector_in;
            stuck_q  <= stuck_in;
         end
      end else if (!paused) begin
         if (stuck_q) begin
            if (cnt == CNT_W'(LIMIT_CYC - 1)) timeout <= 1'b1;
            else                              cnt     <= cnt + 1'b1;
         end else if (cnt == last_cnt) begin
            busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R8
   timeout_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> busy);

   // R8
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !timeout));

   // R9
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !abort) |=> ($stable(kind_q) && $stable(data_q) && $stable(sector_q)));

   // R7
   hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && !abort) |=> $stable(cnt));
endmodule

// File: rtl/fsr_toggle_pair.sv
module fsr_toggle_pair (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic adv6,
   input  logic adv2,
   output logic tog6,
   output logic tog2
);
   logic oe_q;
   logic rd_rise;

   assign rd_rise = oe_n && !oe_q && !ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b1;
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else begin
         oe_q <= oe_n;
         if (rd_rise && adv6) tog6 <= ~tog6;
         if (rd_rise && adv2) tog2 <= ~tog2;
      end
   end

   // R5
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || !oe_n) |=> ($stable(tog6) && $stable(tog2)));

   // R6
   dq2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv2 |=> $stable(tog2));
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
   import fsr_pkg::*;
#(
   parameter int unsigned SECT_W         = 3,
   parameter bit          DQ2_PER_SECTOR = 1'b1
) (
   input  logic              busy,
   input  logic              timeout,
   input  logic              suspended,
   input  op_kind_e          kind_q,
   input  logic              data_msb,
   input  logic [SECT_W-1:0] sector_q,
   input  logic [SECT_W-1:0] rd_sector,
   input  logic              tog6,
   input  logic              tog2,
   input  logic [BYTE_W-1:0] array_data,
   output logic              hit,
   output logic [BYTE_W-1:0] dq_out
);
   logic [BYTE_W-1:0] status;
   logic              show;

   generate
      if (DQ2_PER_SECTOR) begin : g_sect
         assign hit = (kind_q == OP_CERASE) || (rd_sector == sector_q);
      end else begin : g_any
         logic unused_sect;
         assign unused_sect = ^{sector_q, rd_sector};
         assign hit = 1'b1;
      end
   endgenerate

   always_comb begin
      status    = '0;
      status[7] = suspended ? 1'b1 : ((kind_q == OP_PROG) ? ~data_msb : 1'b0);
      status[6] = tog6;
      status[5] = timeout;
      status[3] = (kind_q != OP_PROG);
      status[2] = tog2;
   end

   assign show   = busy && !(suspended && !hit);
   assign dq_out = show ? status : array_data;
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
   import fsr_pkg::*;
#(
   parameter int unsigned PROG_CYC       = 16,
   parameter int unsigned SERASE_CYC     = 64,
   parameter int unsigned CERASE_CYC     = 128,
   parameter int unsigned LIMIT_CYC      = 200,
   parameter int unsigned SECT_W         = 3,
   parameter bit          DQ2_PER_SECTOR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [7:0]        op_data,
   input  logic [SECT_W-1:0] op_sector,
   input  logic              op_stuck,
   input  logic              op_abort,
   input  logic              erase_hold,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [SECT_W-1:0] rd_sector,
   input  logic [7:0]        array_data,
   output logic [7:0]        dq_out
);
   generate
      if (PROG_CYC < 2) begin : g_bad_prog
         $error("PROG_CYC must be at least 2");
      end
      if (SERASE_CYC <= PROG_CYC || CERASE_CYC <= SERASE_CYC) begin : g_bad_order
         $error("durations must grow from program to sector to array erase");
      end
      if (LIMIT_CYC <= CERASE_CYC) begin : g_bad_limit
         $error("LIMIT_CYC must exceed every normal duration");
      end
      if (SECT_W < 1) begin : g_bad_sect
         $error("SECT_W must be at least 1");
      end
   endgenerate

   logic              busy;
   logic              timeout;
   logic              suspended;
   op_kind_e          kind_q;
   logic              data_msb;
   logic [SECT_W-1:0] sector_q;
   logic              hit;
   logic              tog6;
   logic              tog2;
   logic              adv6;
   logic              adv2;

   fsr_op_timer #(
      .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC),
      .LIMIT_CYC(LIMIT_CYC), .SECT_W(SECT_W)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .start(op_start), .kind_in(op_kind_e'(op_kind)),
      .data_in(op_data), .sector_in(op_sector), .stuck_in(op_stuck),
      .abort(op_abort), .hold(erase_hold), .busy(busy), .timeout(timeout),
      .suspended(suspended), .kind_q(kind_q), .data_msb(data_msb), .sector_q(sector_q)
   );

   assign adv6 = busy && !suspended;
   assign adv2 = busy && (kind_q != OP_PROG) && hit;

   fsr_toggle_pair i_toggle (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
      .adv6(adv6), .adv2(adv2), .tog6(tog6), .tog2(tog2)
   );

   fsr_status_mux #(.SECT_W(SECT_W), .DQ2_PER_SECTOR(DQ2_PER_SECTOR)) i_mux (
      .busy(busy), .timeout(timeout), .suspended(suspended), .kind_q(kind_q),
      .data_msb(data_msb), .sector_q(sector_q), .rd_sector(rd_sector),
      .tog6(tog6), .tog2(tog2), .array_data(array_data), .hit(hit), .dq_out(dq_out)
   );

   // R1
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dq_out == array_data));

   // R2
   prog_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == OP_PROG) |-> (dq_out[7] != data_msb));

   // R3
   erase_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q != OP_PROG && !suspended) |-> (!dq_out[7] && dq_out[3]));
endmodule

// File: tb/test_flash_op_status.sv
`timescale 1ns/1ps
module test_flash_op_status;
   localparam int PROG_CYC   = 16;
   localparam int SERASE_CYC = 64;
   localparam int CERASE_CYC = 128;
   localparam int LIMIT_CYC  = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic [7:0] op_data = 8'h00;
   logic [2:0] op_sector = 3'd0;
   logic       op_stuck = 1'b0;
   logic       op_abort = 1'b0;
   logic       erase_hold = 1'b0;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic [2:0] rd_sector = 3'd0;
   logic [7:0] array_data = 8'h5A;
   logic [7:0] dq_out;

   int  total = 0;
   int  bad   = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   flash_op_status i_flash_op_status (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .op_data(op_data), .op_sector(op_sector), .op_stuck(op_stuck),
      .op_abort(op_abort), .erase_hold(erase_hold), .ce_n(ce_n), .oe_n(oe_n),
      .rd_sector(rd_sector), .array_data(array_data), .dq_out(dq_out)
   );

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic start_op(input logic [1:0] k, input logic [7:0] d, input logic [2:0] s, input logic stuck);
      @(negedge clk);
      op_kind = k; op_data = d; op_sector = s; op_stuck = stuck; op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0; op_stuck = 1'b0;
   endtask

   task automatic abort_op();
      @(negedge clk) op_abort = 1'b1;
      @(negedge clk) op_abort = 1'b0;
   endtask

   task automatic do_read(input logic [2:0] s, output logic [7:0] v);
      @(negedge clk);
      ce_n = 1'b0; rd_sector = s; oe_n = 1'b0;
      @(negedge clk);
      v = dq_out; oe_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (dq_out != array_data && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      #1 chk(dq_out == 8'h5A, "R10 reset passthrough", dq_out, 8'h5A);
      @(negedge clk) array_data = 8'hC3;
      #1 chk(dq_out == 8'hC3, "R1 idle passthrough", dq_out, 8'hC3);
   endtask

   task automatic t_program();
      logic [7:0] r0, r1, r2;
      int n;
      array_data = 8'h00;
      start_op(2'd0, 8'h15, 3'd0, 1'b0);
      do_read(3'd0, r0); do_read(3'd0, r1); do_read(3'd0, r2);
      chk(r0[7] == 1'b1, "R2 dq7 inverted", r0, 8'h80);
      chk({r0[5:3], r0[1:0]} == 5'b0, "R2 idle bits zero", r0, {1'b1, r0[6], 3'b000, r0[2], 2'b00});
      chk(r1[6] != r0[6] && r2[6] != r1[6], "R4 dq6 alternates", r2, {r1[7], ~r1[6], r1[5:0]});
      chk(r1[2] == r0[2] && r2[2] == r1[2], "R6 dq2 steady in program", r2, r0);
      wait_idle(n);
      chk(dq_out == array_data, "R2 data after finish", dq_out, array_data);
      start_op(2'd0, 8'h80, 3'd0, 1'b0);
      chk(dq_out[7] == 1'b0, "R2 dq7 inverted high", dq_out, 8'h00);
      wait_idle(n);
   endtask

   task automatic t_duration();
      int n;
      array_data = 8'h00;
      start_op(2'd0, 8'h00, 3'd0, 1'b0); wait_idle(n);
      chk(n == PROG_CYC, "R2 program length", 8'(n), 8'(PROG_CYC));
      start_op(2'd1, 8'h00, 3'd3, 1'b0); wait_idle(n);
      chk(n == SERASE_CYC, "R3 sector erase length", 8'(n), 8'(SERASE_CYC));
      start_op(2'd2, 8'h00, 3'd0, 1'b0); wait_idle(n);
      chk(n == CERASE_CYC, "R3 array erase length", 8'(n), 8'(CERASE_CYC));
   endtask

   task automatic t_erase_toggles();
      logic [7:0] a, b, c, d, e, f, g;
      array_data = 8'h00;
      start_op(2'd1, 8'h00, 3'd2, 1'b0);
      do_read(3'd2, a); do_read(3'd2, b); do_read(3'd2, c);
      do_read(3'd5, d); do_read(3'd5, e);
      chk(a[7] == 1'b0 && a[3] == 1'b1, "R3 erase flags", a, {1'b0, a[6:4], 1'b1, a[2:0]});
      chk(b[6] != a[6], "R4 dq6 alternates in erase", b, {b[7], ~a[6], b[5:0]});
      chk(b[2] != a[2] && c[2] != b[2], "R6 dq2 flips on erasing sector", c, {c[7:3], ~b[2], c[1:0]});
      chk(e[2] == d[2], "R6 dq2 holds on other sector", e, d);
      chk(e[6] != d[6], "R4 dq6 flips on other sector", e, {e[7], ~d[6], e[5:0]});
      abort_op();
      #1 chk(dq_out == array_data, "R8 abort returns data", dq_out, array_data);
      start_op(2'd2, 8'h00, 3'd0, 1'b0);
      do_read(3'd6, f); do_read(3'd6, g);
      chk(g[2] != f[2], "R6 dq2 flips in array erase", g, {g[7:3], ~f[2], g[1:0]});
      abort_op();
   endtask

   task automatic t_ce_gate();
      logic [7:0] a, b, c;
      array_data = 8'h00;
      start_op(2'd0, 8'h00, 3'd0, 1'b0);
      do_read(3'd0, a);
      @(negedge clk) begin ce_n = 1'b1; oe_n = 1'b0; end
      @(negedge clk) oe_n = 1'b1;
      do_read(3'd0, b);
      chk(b[6] != a[6], "R5 no advance with ce high", b, {b[7], ~a[6], b[5:0]});
      @(negedge clk) oe_n = 1'b0;
      @(negedge clk) oe_n = 1'b1;
      do_read(3'd0, c);
      chk(c[6] != b[6], "R5 second gated pulse ignored", c, {c[7], ~b[6], c[5:0]});
      abort_op();
   endtask

   task automatic t_suspend();
      logic [7:0] v, a, b;
      int n;
      array_data = 8'h3C;
      start_op(2'd1, 8'h00, 3'd1, 1'b0);
      repeat (5) @(negedge clk);
      erase_hold = 1'b1;
      do_read(3'd4, v);
      chk(v == 8'h3C, "R7 other sector reads array", v, 8'h3C);
      do_read(3'd1, a); do_read(3'd1, b);
      chk(a[7] == 1'b1, "R7 dq7 high in hold", a, {1'b1, a[6:0]});
      chk(b[6] == a[6], "R7 dq6 steady in hold", b, {b[7], a[6], b[5:0]});
      chk(b[2] != a[2], "R7 dq2 flips in hold", b, {b[7:3], ~a[2], b[1:0]});
      repeat (SERASE_CYC + 10) @(negedge clk);
      #1 chk(dq_out != array_data && dq_out[7], "R7 counter frozen", dq_out, {1'b1, dq_out[6:0]});
      erase_hold = 1'b0;
      #1 wait_idle(n);
      chk(n > 0 && n < SERASE_CYC, "R7 resumes remainder", 8'(n), 8'(SERASE_CYC - 6));
   endtask

   task automatic t_timeout();
      array_data = 8'h00;
      start_op(2'd0, 8'h00, 3'd0, 1'b1);
      repeat (LIMIT_CYC - 1) @(negedge clk);
      #1 chk(dq_out[5] == 1'b0, "R8 dq5 low before limit", dq_out, {dq_out[7:6], 1'b0, dq_out[4:0]});
      @(negedge clk);
      #1 chk(dq_out[5] == 1'b1, "R8 dq5 high at limit", dq_out, {dq_out[7:6], 1'b1, dq_out[4:0]});
      repeat (50) @(negedge clk);
      #1 chk(dq_out[5] == 1'b1 && dq_out[7] == 1'b1, "R8 busy kept after overrun", dq_out, 8'hA0);
      abort_op();
      #1 chk(dq_out == array_data, "R8 abort clears overrun", dq_out, array_data);
   endtask

   task automatic t_ignore();
      array_data = 8'h00;
      start_op(2'd1, 8'h00, 3'd0, 1'b0);
      start_op(2'd0, 8'h00, 3'd0, 1'b0);
      #1 chk(dq_out[3] == 1'b1 && dq_out[7] == 1'b0, "R9 start while busy ignored", dq_out, 8'h08);
      abort_op();
      start_op(2'd3, 8'h00, 3'd0, 1'b0);
      #1 chk(dq_out == array_data, "R9 unused kind ignored", dq_out, array_data);
   endtask

   task automatic t_midreset();
      array_data = 8'h00;
      start_op(2'd0, 8'h00, 3'd0, 1'b0);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      #1 chk(dq_out == array_data, "R10 reset ends operation", dq_out, array_data);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_duration();
      t_erase_toggles();
      t_ce_gate();
      t_suspend();
      t_timeout();
      t_ignore();
      t_midreset();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule